// File: doc/BRIEF.md
# Boot-Stage Sector Isolation Controller

This block keeps a boot-time protection level that only ever climbs, from 0 up to the final level 3, and rules on every flash sector access against that level. Each flash bank has a protected level-1 sector range, given by a first and a last sector number. These are captured from configuration inputs while reset is held. A volatile extension count widens the hidden range past the level-1 range once the final level is reached. The count can only grow. It freezes at level 3 and clears at every reset.

Boot software raises the level through a one-cycle increment pulse and programs the extension count through a plain write strobe. Access queries arrive on a valid/ready request stream as bank plus sector. The answers leave on a valid/ready response stream that holds one entry. A new request is taken only when the response slot is empty or is being drained in the same cycle. While `rsp_ready` stays low, the response and its allow bit hold steady and `req_ready` stays low.

Top module: `iso_level_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the level becomes 0, `inc_err` becomes 0, the extension count becomes 0 and `rsp_valid` becomes 0. At that edge the per-bank first and last sectors are captured from `cfg_first` and `cfg_last`, where bank b occupies bits [b*SW +: SW] and SW is the sector index width.
- R2: Each clock edge with `lvl_inc` high and the level below 3 raises the level by exactly one. The level never decreases except through reset.
- R3: A `lvl_inc` at level 3 leaves the level at 3 and sets `inc_err`. `inc_err` then stays set until reset.
- R4: An `ext_wr` is taken only when its value is at least the current extension count and the level is below 3. A smaller value leaves the count unchanged.
- R5: At level 3 every `ext_wr` is ignored. A write in the same cycle as the step from 2 to 3 is judged at level 2, so it is taken.
- R6: At levels 0 and 1 every access is allowed.
- R7: At level 2 or 3, sector s of bank b is denied when first(b) <= s <= last(b). If first(b) > last(b), the bank has no level-1 range.
- R8: At level 3, sectors last(b)+1 through min(last(b)+ext, NSECT-1) of bank b are also denied. An extension of 0 hides nothing extra.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request yields `rsp_valid` with its `rsp_allow` after the next clock edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_allow` holds.
- R10: A decision uses the level and extension count as they stood in the acceptance cycle, before any update at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| cfg_first | input | NBANK*SW | First level-1 sector per bank |
| cfg_last | input | NBANK*SW | Last level-1 sector per bank |
| lvl_inc | input | 1 | Level increment request, one per cycle high |
| ext_wr | input | 1 | Extension count write strobe |
| ext_wdata | input | EXT_W | Extension count write value |
| req_valid | input | 1 | Access query valid |
| req_ready | output | 1 | Access query accepted this cycle |
| req_bank | input | BW | Bank of the query |
| req_sector | input | SW | Sector of the query |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Decision consumer ready |
| rsp_allow | output | 1 | 1 = access allowed, 0 = denied |
| level | output | 2 | Current protection level |
| inc_err | output | 1 | Sticky flag for an increment at level 3 |

## Verification
Level and extension updates take effect at the clock edge where the strobe is seen, so the level is checked at the falling edge right after that edge. An extension write is confirmed at the ports by a query one cycle later. A query handed over at a rising edge has its decision on `rsp_valid`/`rsp_allow` from that edge onward. The bench drives on falling edges and compares at the next falling edge. Under back-pressure it checks the held decision on each stalled falling edge. It then checks that the draining edge also takes the queued query, whose decision appears at the falling edge after it.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_RESET = 2'd0;
  localparam lvl_t LVL_LOCK1 = 2'd2;
  localparam lvl_t LVL_FINAL = 2'd3;
endpackage

// File: rtl/iso_level_ctr.sv
module iso_level_ctr
  import iso_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output lvl_t lvl,
  output logic err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= LVL_RESET;
      err <= 1'b0;
    end else if (inc) begin
      if (lvl == LVL_FINAL) err <= 1'b1;
      else                  lvl <= lvl + 2'd1;
    end
  end

  // R2
  lvl_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (lvl >= $past(lvl)));
  // R3
  inc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && lvl == LVL_FINAL) |=> (err && lvl == LVL_FINAL));
endmodule

// File: rtl/iso_ext_reg.sv
module iso_ext_reg
  import iso_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lvl_t             lvl,
  input  logic             wr,
  input  logic [EXT_W-1:0] wdata,
  output logic [EXT_W-1:0] ext
);
  logic take;
  assign take = wr && (lvl != LVL_FINAL) && (wdata >= ext);

  always_ff @(posedge clk) begin
    if (!rst_n)    ext <= '0;
    else if (take) ext <= wdata;
  end

  // R4
  ext_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ext >= $past(ext)));
  // R5
  ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LVL_FINAL) |=> $stable(ext));
endmodule

// File: rtl/iso_bank_rule.sv
module iso_bank_rule
  import iso_pkg::*;
#(
  parameter int NSECT = 128,
  parameter int EXT_W = 8,
  localparam int SW    = $clog2(NSECT),
  localparam int SUM_W = ((SW > EXT_W) ? SW : EXT_W) + 1
) (
  input  lvl_t             lvl,
  input  logic [EXT_W-1:0] ext,
  input  logic [SW-1:0]    first,
  input  logic [SW-1:0]    last,
  input  logic [SW-1:0]    sector,
  output logic             deny
);
  localparam logic [SUM_W-1:0] LAST_SECT = SUM_W'(NSECT - 1);

  logic [SUM_W-1:0] sec_w, last_w, top_w, lim_w;
  logic in_l1, in_ext;

  always_comb begin
    sec_w  = {{(SUM_W-SW){1'b0}}, sector};
    last_w = {{(SUM_W-SW){1'b0}}, last};
    top_w  = last_w + {{(SUM_W-EXT_W){1'b0}}, ext};
    lim_w  = (top_w > LAST_SECT) ? LAST_SECT : top_w;
    in_l1  = (sector >= first) && (sector <= last);
    in_ext = (sec_w > last_w) && (sec_w <= lim_w);
    deny   = ((lvl >= LVL_LOCK1) && in_l1) || ((lvl == LVL_FINAL) && in_ext);
  end
endmodule

// File: rtl/iso_level_ctrl.sv
module iso_level_ctrl
  import iso_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int NSECT = 128,
  parameter int EXT_W = 8,
  localparam int SW = $clog2(NSECT),
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*SW-1:0] cfg_first,
  input  logic [NBANK*SW-1:0] cfg_last,
  input  logic                lvl_inc,
  input  logic                ext_wr,
  input  logic [EXT_W-1:0]    ext_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [BW-1:0]       req_bank,
  input  logic [SW-1:0]       req_sector,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_allow,
  output logic [1:0]          level,
  output logic                inc_err
);
  lvl_t             lvl;
  logic [EXT_W-1:0] ext;
  logic [SW-1:0]    first_q [NBANK];
  logic [SW-1:0]    last_q  [NBANK];
  logic [NBANK-1:0] deny_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        first_q[b] <= cfg_first[b*SW +: SW];
        last_q[b]  <= cfg_last[b*SW +: SW];
      end
    end
  end

  iso_level_ctr u_lvl (.clk(clk), .rst_n(rst_n), .inc(lvl_inc), .lvl(lvl), .err(inc_err));

  iso_ext_reg #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .wr(ext_wr), .wdata(ext_wdata), .ext(ext));

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    iso_bank_rule #(.NSECT(NSECT), .EXT_W(EXT_W)) u_rule (
      .lvl(lvl), .ext(ext), .first(first_q[g]), .last(last_q[g]),
      .sector(req_sector), .deny(deny_vec[g]));
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign level     = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b1;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_allow <= !deny_vec[req_bank];
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow)));
  // R6
  low_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lvl < LVL_LOCK1) |=> rsp_allow);
endmodule

// File: tb/sim_iso_level_ctrl.sv
module sim_iso_level_ctrl;
  localparam int NBANK = 2, NSECT = 128, EXT_W = 8, SW = 7;
  logic clk = 0, rst_n = 0;
  logic [NBANK*SW-1:0] cfg_first, cfg_last;
  logic lvl_inc = 0, ext_wr = 0, req_valid = 0, rsp_ready = 1;
  logic [EXT_W-1:0] ext_wdata = 0;
  logic req_bank = 0;
  logic [SW-1:0] req_sector = 0;
  logic req_ready, rsp_valid, rsp_allow, inc_err;
  logic [1:0] level;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  iso_level_ctrl #(.NBANK(NBANK), .NSECT(NSECT), .EXT_W(EXT_W)) u0 (
    .clk, .rst_n, .cfg_first, .cfg_last, .lvl_inc, .ext_wr, .ext_wdata,
    .req_valid, .req_ready, .req_bank, .req_sector, .rsp_valid, .rsp_ready,
    .rsp_allow, .level, .inc_err);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [SW-1:0] f0, l0, f1, l1);
    @(negedge clk);
    rst_n = 0; cfg_first = {f1, f0}; cfg_last = {l1, l0};
    lvl_inc = 0; ext_wr = 0; req_valid = 0; rsp_ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cfg_first = '0; cfg_last = '0;
  endtask

  task automatic inc_lvl();
    lvl_inc = 1; @(negedge clk); lvl_inc = 0;
  endtask

  task automatic wr_ext(input int v);
    ext_wr = 1; ext_wdata = EXT_W'(v); @(negedge clk); ext_wr = 0;
  endtask

  task automatic query(input int bank, input int sec, input int exp, input string req);
    req_valid = 1; req_bank = bank[0]; req_sector = SW'(sec);
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, rsp_valid, 1);
    chk({req, " allow"}, rsp_allow, exp);
  endtask

  task automatic t_reset();
    do_reset(4, 9, 100, 120);
    chk("R1 level", level, 0);
    chk("R1 inc_err", inc_err, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_low_levels();
    query(0, 5, 1, "R6 lvl0 l1 area");
    inc_lvl();
    chk("R2 step to 1", level, 1);
    query(1, 110, 1, "R6 lvl1 l1 area");
  endtask

  task automatic t_same_cycle();
    // R10: query with increment 1->2 in the same cycle judged at level 1
    lvl_inc = 1; req_valid = 1; req_bank = 0; req_sector = 7;
    @(negedge clk);
    lvl_inc = 0; req_valid = 0;
    chk("R10 old level allow", rsp_allow, 1);
    chk("R2 step to 2", level, 2);
    query(0, 7, 0, "R7 lvl2 inside");
    query(0, 4, 0, "R7 lvl2 first edge");
    query(0, 9, 0, "R7 lvl2 last edge");
    query(0, 3, 1, "R7 lvl2 below");
    query(0, 10, 1, "R7 lvl2 ext not active");
    query(1, 120, 0, "R7 lvl2 bank1");
  endtask

  task automatic t_ext_and_final();
    wr_ext(5);
    wr_ext(3);  // R4 smaller ignored
    // R5: write 20 together with step 2->3 is taken
    lvl_inc = 1; ext_wr = 1; ext_wdata = 20; @(negedge clk);
    lvl_inc = 0; ext_wr = 0;
    chk("R2 step to 3", level, 3);
    query(0, 29, 0, "R5 same-cycle write taken");
    query(0, 30, 1, "R8 past extension");
    query(0, 14, 0, "R4 smaller write ignored");
    query(1, 127, 0, "R8 clamp last sector");
    query(1, 121, 0, "R8 bank1 ext start");
    query(1, 99, 1, "R7 bank1 below first");
    wr_ext(40);
    query(0, 30, 1, "R5 write at final ignored");
    inc_lvl();
    chk("R3 level stays", level, 3);
    chk("R3 err set", inc_err, 1);
    repeat (3) @(negedge clk);
    chk("R3 err sticky", inc_err, 1);
  endtask

  task automatic t_backpressure();
    rsp_ready = 0;
    req_valid = 1; req_bank = 0; req_sector = 50;
    @(negedge clk);
    chk("R9 first held valid", rsp_valid, 1);
    chk("R9 first allow", rsp_allow, 1);
    chk("R9 ready low", req_ready, 0);
    req_sector = 5;
    @(negedge clk);
    chk("R9 stall allow held", rsp_allow, 1);
    chk("R9 stall ready low", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 second valid", rsp_valid, 1);
    chk("R9 second allow", rsp_allow, 0);
    @(negedge clk);
    chk("R9 drained", rsp_valid, 0);
  endtask

  task automatic t_reset_again();
    do_reset(20, 10, 0, 0);
    chk("R1 level back to 0", level, 0);
    chk("R1 err cleared", inc_err, 0);
    inc_lvl(); inc_lvl(); inc_lvl();
    chk("R2 reached 3", level, 3);
    query(0, 15, 1, "R7 empty range");
    query(0, 11, 1, "R8 ext cleared by reset");
    query(1, 0, 0, "R7 single-sector range");
    query(1, 1, 1, "R8 zero ext hides nothing");
  endtask

  initial begin
    t_reset();
    t_low_levels();
    t_same_cycle();
    t_ext_and_final();
    t_backpressure();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule